// File: doc/BRIEF.md
# Fixed-Priority Slave-Port Arbiter

This block guards a single slave port inside a small bus crossbar that serves four masters. Each master presents a request made of a valid flag, an address, a write flag and write data, and holds it until it sees ready. The block checks each address against the slave's window. Requests that fall inside the window compete for the port. A request that falls outside is completed at once with an error, and it never reaches the slave.

Competition uses fixed priority levels set at build time. By default master 0 has level 7, master 1 has 6, master 2 has 5 and master 3 has 4, and the larger level wins. The owner of the port is checked again on every clock. Ownership can move only at a transfer boundary. A move always leaves exactly one idle cycle on the slave side. A master that keeps ownership can issue transfers back to back with no gaps. The slave's ready, read data and error go only to the owning master.

Top module: `fixedprio_port_arb`

## Requirements
- R1: After reset no master owns the port, `sValid` is low, and every `mReady`, `mErr` and `mRdata` is zero until a request arrives.
- R2: An address `a` with 0x4000 <= a < 0x6000 maps to the slave. Any other address completes in the same cycle with `mReady` and `mErr` high for that master and raises no slave request, even while another master holds the port.
- R3: Priority levels are 7, 6, 5 and 4 for masters 0, 1, 2 and 3. When several masters contend at a boundary, the numerically larger level wins.
- R4: If a master asks for the port while it does not own it and the port is idle, `sValid` for that request rises one cycle after the request is first presented. If the idle owner asks again, the request is issued in the same cycle.
- R5: With a zero-wait slave, an owner that keeps requesting gets one transfer per cycle, and `sValid` stays high with no idle cycles.
- R6: If a higher-level master is waiting when the owner's transfer is accepted, it takes the port. The slave sees exactly one idle cycle before the new owner's first transfer.
- R7: A waiting master with a lower level than the owner never interrupts an owner that keeps requesting.
- R8: While the slave holds a transfer with `sReady` low, the owner does not change and `sAddr` stays the same.
- R9: When the owner stops requesting, the highest-level waiting master gets the port after exactly one idle slave cycle.
- R10: `sErr` is passed to the owner's `mErr` on completion. No other error is raised by the block except the decode miss of R2.
- R11: Only the owner receives `sRdata` on `mRdata`. The `mRdata` lanes of other masters read zero, and a non-owner with a mapped address sees `mReady` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mValid | input | 4 | Per-master request valid, held until ready |
| mAddr | input | 64 | Per-master address, master i in bits [16i+15:16i] |
| mWrite | input | 4 | Per-master write flag |
| mWdata | input | 128 | Per-master write data, master i in bits [32i+31:32i] |
| mReady | output | 4 | Per-master transfer completion |
| mErr | output | 4 | Per-master error, only valid with mReady |
| mRdata | output | 128 | Per-master read data, zero for non-owners |
| sValid | output | 1 | Slave request valid |
| sAddr | output | 16 | Slave request address |
| sWrite | output | 1 | Slave request write flag |
| sWdata | output | 32 | Slave request write data |
| sReady | input | 1 | Slave accepts and completes the transfer |
| sRdata | input | 32 | Slave read data |
| sErr | input | 1 | Slave error response |

## Verification
If the owner register or the handoff-gap flag holds a wrong value, it shows up on `sAddr` and `mReady` in the very next cycle. The wrong master's address appears on the slave, or an idle cycle is missing or added around a handoff. The bench therefore checks, cycle by cycle, the exact cycle in which `sValid` rises after every ordered pair of masters hands over the port, and does the same for preemption, release and waited transfers. A decode fault shows up in the same cycle as a missing or unwanted error completion. The bench checks that at both edges of the window.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  // Strobes handed from the arbitration control to the datapath.
  typedef struct packed {
    logic owned;   // some master holds the port
    logic drive;   // present the owner's request to the slave this cycle
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import prio_arb_pkg::*;
#(
  parameter int NM = 4,
  parameter int PW = 3,
  parameter logic [NM*PW-1:0] PRIO = {3'd4, 3'd5, 3'd6, 3'd7},
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NM-1:0] reqHit,
  input  logic          sReady,
  output arbStrobe_t    strobe,
  output logic [IW-1:0] ownerIdx
);

  logic [IW-1:0] ownerQ;
  logic          ownedQ;
  logic          gapQ;

  logic          drive;
  logic          accept;
  logic          boundary;
  logic [NM-1:0] cand;
  logic [IW-1:0] bestIdx;
  logic [PW-1:0] bestPrio;
  logic          found;
  logic          switchNow;

  function automatic logic [PW-1:0] prioOf(input logic [IW-1:0] idx);
    return PRIO[idx*PW +: PW];
  endfunction

  // The owner reaches the slave only while it is requesting and not in a handoff gap.
  assign drive    = ownedQ && !gapQ && reqHit[ownerQ];
  assign accept   = drive && sReady;
  assign boundary = !drive || accept;

  // The owner's own request leaves the contest in the cycle it completes.
  always_comb begin
    cand = reqHit;
    if (accept) cand[ownerQ] = 1'b0;
  end

  always_comb begin
    bestIdx  = '0;
    bestPrio = '0;
    found    = 1'b0;
    for (int k = 0; k < NM; k++) begin
      if (cand[k] && (!found || prioOf(IW'(k)) > bestPrio)) begin
        found    = 1'b1;
        bestIdx  = IW'(k);
        bestPrio = prioOf(IW'(k));
      end
    end
  end

  always_comb begin
    switchNow = 1'b0;
    if (boundary && found) begin
      if (accept) switchNow = bestPrio > prioOf(ownerQ);
      else        switchNow = !ownedQ || (bestIdx != ownerQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= '0;
      ownedQ <= 1'b0;
      gapQ   <= 1'b0;
    end else if (switchNow) begin
      ownerQ <= bestIdx;
      ownedQ <= 1'b1;
      // A handoff straight after a busy cycle leaves the next slave cycle idle.
      gapQ   <= accept;
    end else begin
      gapQ   <= 1'b0;
    end
  end

  assign strobe.owned = ownedQ;
  assign strobe.drive = drive;
  assign ownerIdx     = ownerQ;

  // R3: levels must be unique so that no tie can arise.
  initial begin
    for (int i = 0; i < NM; i++) begin
      for (int j = i + 1; j < NM; j++) begin
        a_r3_unique_levels: assert (PRIO[i*PW +: PW] != PRIO[j*PW +: PW])
          else $error("priority levels of masters %0d and %0d collide", i, j);
      end
    end
  end

  // R8: a transfer the slave is holding pins the owner.
  a_r8_hold_owner: assert property (@(posedge clk) disable iff (!rstN)
    (drive && !sReady) |=> (ownedQ && ownerQ == $past(ownerQ)));

  // R6 / R9: any change of owner is separated by an idle slave cycle.
  a_r6_idle_on_handoff: assert property (@(posedge clk) disable iff (!rstN)
    (ownedQ && $past(ownedQ) && ownerQ != $past(ownerQ)) |-> !(drive && $past(drive)));

  // R3 / R7: taking the port from a busy owner needs a strictly higher level.
  a_r3_preempt_higher: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accept) && ownerQ != $past(ownerQ)) |-> (prioOf(ownerQ) > prioOf($past(ownerQ))));

  // R1: ownership, once taken, is never dropped.
  a_r1_owned_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ownedQ |=> ownedQ);

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import prio_arb_pkg::*;
#(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 16'h4000,
  parameter logic [AW-1:0] SIZE = 16'h2000,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1,
  localparam logic [AW:0] LOW = {1'b0, BASE},
  localparam logic [AW:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NM-1:0]    mValid,
  input  logic [NM*AW-1:0] mAddr,
  input  logic [NM-1:0]    mWrite,
  input  logic [NM*DW-1:0] mWdata,
  output logic [NM-1:0]    mReady,
  output logic [NM-1:0]    mErr,
  output logic [NM*DW-1:0] mRdata,
  input  arbStrobe_t       strobe,
  input  logic [IW-1:0]    ownerIdx,
  output logic [NM-1:0]    reqHit,
  output logic             sValid,
  output logic [AW-1:0]    sAddr,
  output logic             sWrite,
  output logic [DW-1:0]    sWdata,
  input  logic             sReady,
  input  logic [DW-1:0]    sRdata,
  input  logic             sErr
);

  logic [NM-1:0] hit;

  for (genvar g = 0; g < NM; g++) begin : gLane
    logic [AW:0] addrX;
    logic        isOwner;
    logic        done;
    logic        miss;

    assign addrX   = {1'b0, mAddr[g*AW +: AW]};
    assign hit[g]  = (addrX >= LOW) && (addrX < LIMIT);
    assign reqHit[g] = mValid[g] && hit[g];
    assign isOwner = strobe.owned && (ownerIdx == IW'(g));
    assign done    = isOwner && strobe.drive && sReady;
    assign miss    = mValid[g] && !hit[g];

    assign mReady[g] = done || miss;
    assign mErr[g]   = (done && sErr) || miss;
    assign mRdata[g*DW +: DW] = isOwner ? sRdata : '0;

    // R10: an error is only ever reported together with completion.
    a_r10_err_with_ready: assert property (@(posedge clk) disable iff (!rstN)
      mErr[g] |-> mReady[g]);
  end

  // The owner's request goes to the slave; the bus rests at zero otherwise.
  assign sValid = strobe.drive;
  assign sAddr  = strobe.drive ? mAddr[ownerIdx*AW +: AW] : '0;
  assign sWrite = strobe.drive && mWrite[ownerIdx];
  assign sWdata = strobe.drive ? mWdata[ownerIdx*DW +: DW] : '0;

  // R2: the slave never sees an address outside its window.
  a_r2_slave_in_window: assert property (@(posedge clk) disable iff (!rstN)
    sValid |-> (({1'b0, sAddr} >= LOW) && ({1'b0, sAddr} < LIMIT)));

  // R11: at most one master completes a slave transfer per cycle.
  a_r11_single_completion: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mReady & hit) <= 1);

  // R8: a transfer held by the slave keeps its address.
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && !sReady && $past(sValid && !sReady)) |-> $stable(sAddr) || !$stable(ownerIdx));

endmodule

// File: rtl/fixedprio_port_arb.sv
module fixedprio_port_arb
  import prio_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 3,
  parameter logic [NUM_MASTERS*PRIO_W-1:0] MASTER_PRIO = {3'd4, 3'd5, 3'd6, 3'd7},
  parameter logic [ADDR_W-1:0] REGION_BASE = 16'h4000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 16'h2000,
  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        mValid,
  input  logic [NUM_MASTERS*ADDR_W-1:0] mAddr,
  input  logic [NUM_MASTERS-1:0]        mWrite,
  input  logic [NUM_MASTERS*DATA_W-1:0] mWdata,
  output logic [NUM_MASTERS-1:0]        mReady,
  output logic [NUM_MASTERS-1:0]        mErr,
  output logic [NUM_MASTERS*DATA_W-1:0] mRdata,
  output logic                          sValid,
  output logic [ADDR_W-1:0]             sAddr,
  output logic                          sWrite,
  output logic [DATA_W-1:0]             sWdata,
  input  logic                          sReady,
  input  logic [DATA_W-1:0]             sRdata,
  input  logic                          sErr
);

  arbStrobe_t             strobe;
  logic [IW-1:0]          ownerIdx;
  logic [NUM_MASTERS-1:0] reqHit;

  arb_ctrl #(
    .NM  (NUM_MASTERS),
    .PW  (PRIO_W),
    .PRIO(MASTER_PRIO)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqHit  (reqHit),
    .sReady  (sReady),
    .strobe  (strobe),
    .ownerIdx(ownerIdx)
  );

  arb_datapath #(
    .NM  (NUM_MASTERS),
    .AW  (ADDR_W),
    .DW  (DATA_W),
    .BASE(REGION_BASE),
    .SIZE(REGION_SIZE)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .mValid  (mValid),
    .mAddr   (mAddr),
    .mWrite  (mWrite),
    .mWdata  (mWdata),
    .mReady  (mReady),
    .mErr    (mErr),
    .mRdata  (mRdata),
    .strobe  (strobe),
    .ownerIdx(ownerIdx),
    .reqHit  (reqHit),
    .sValid  (sValid),
    .sAddr   (sAddr),
    .sWrite  (sWrite),
    .sWdata  (sWdata),
    .sReady  (sReady),
    .sRdata  (sRdata),
    .sErr    (sErr)
  );

endmodule

// File: tb/sim_fixedprio_port_arb.sv
module sim_fixedprio_port_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NM-1:0]    mValid = '0;
  logic [NM*AW-1:0] mAddr = '0;
  logic [NM-1:0]    mWrite = '0;
  logic [NM*DW-1:0] mWdata = '0;
  logic [NM-1:0]    mReady;
  logic [NM-1:0]    mErr;
  logic [NM*DW-1:0] mRdata;
  logic             sValid;
  logic [AW-1:0]    sAddr;
  logic             sWrite;
  logic [DW-1:0]    sWdata;
  logic             sReady = 1'b1;
  logic [DW-1:0]    sRdata;
  logic             sErr = 1'b0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] slaveData(input logic [AW-1:0] a);
    return {a ^ 16'hC3C3, ~a};
  endfunction

  assign sRdata = slaveData(sAddr);

  fixedprio_port_arb u0 (
    .clk(clk), .rstN(rstN), .mValid(mValid), .mAddr(mAddr), .mWrite(mWrite),
    .mWdata(mWdata), .mReady(mReady), .mErr(mErr), .mRdata(mRdata),
    .sValid(sValid), .sAddr(sAddr), .sWrite(sWrite), .sWdata(sWdata),
    .sReady(sReady), .sRdata(sRdata), .sErr(sErr)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic nextCyc();
    @(posedge clk);
    #1;
  endtask

  task automatic setReq(input int i, input bit v, input logic [AW-1:0] a);
    mValid[i] = v;
    mAddr[i*AW +: AW] = a;
    mWdata[i*DW +: DW] = {a, ~a};
    mWrite[i] = a[0];
  endtask

  // One transfer from master i; expLat < 0 leaves the latency unchecked.
  task automatic xfer(input int i, input logic [AW-1:0] a, input int expLat, input bit expErr, input string req);
    int lat = 0;
    setReq(i, 1'b1, a);
    settle();
    while (!mReady[i] && lat < 8) begin
      nextCyc();
      lat++;
      settle();
    end
    if (expLat >= 0) chk(req, "grant latency", 64'(lat), 64'(expLat));
    chk("R11", "owner read data", 64'(mRdata[i*DW +: DW]), 64'(slaveData(a)));
    chk("R10", "owner error", 64'(mErr[i]), 64'(expErr));
    for (int j = 0; j < NM; j++) begin
      if (j != i) begin
        chk("R11", "non-owner read data", 64'(mRdata[j*DW +: DW]), 64'h0);
        chk("R10", "non-owner error", 64'(mErr[j]), 64'h0);
      end
    end
    nextCyc();
    setReq(i, 1'b0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual 20000 cycles expected fewer");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] missList [4];
    missList[0] = 16'h0000; missList[1] = 16'h3FFF;
    missList[2] = 16'h6000; missList[3] = 16'hFFFF;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: quiet after reset
    settle();
    chk("R1", "sValid", 64'(sValid), 64'h0);
    chk("R1", "mReady", 64'(mReady), 64'h0);
    chk("R1", "mErr", 64'(mErr), 64'h0);
    chk("R1", "mRdata", 64'(|mRdata), 64'h0);
    nextCyc();

    // R4: first grant after reset costs one cycle, parked owner none
    xfer(2, 16'h4100, 1, 1'b0, "R4");
    xfer(2, 16'h4104, 0, 1'b0, "R4");

    // R2: both edges of the window map to the slave
    xfer(0, 16'h4000, 1, 1'b0, "R2");
    xfer(0, 16'h5FFF, 0, 1'b0, "R2");

    // R4 / R9: every ordered handoff from an idle owner
    for (int a = 0; a < NM; a++) begin
      for (int b = 0; b < NM; b++) begin
        if (a != b) begin
          xfer(a, 16'(16'h4000 + a*16 + b), -1, 1'b0, "R4");
          xfer(b, 16'(16'h4800 + a*16 + b), 1, 1'b0, "R4");
          xfer(b, 16'(16'h4C00 + a*16 + b), 0, 1'b0, "R4");
        end
      end
    end

    // R2: decode misses complete at once with an error
    for (int i = 0; i < NM; i++) begin
      for (int k = 0; k < 4; k++) begin
        setReq(i, 1'b1, missList[k]);
        settle();
        chk("R2", "miss ready", 64'(mReady[i]), 64'h1);
        chk("R2", "miss error", 64'(mErr[i]), 64'h1);
        chk("R2", "miss no slave request", 64'(sValid), 64'h0);
        nextCyc();
        setReq(i, 1'b0, '0);
      end
    end

    // R5: back-to-back stream by the owner
    xfer(0, 16'h4200, -1, 1'b0, "R5");
    setReq(0, 1'b1, 16'h4210);
    for (int k = 0; k < 6; k++) begin
      settle();
      chk("R5", "stream sValid", 64'(sValid), 64'h1);
      chk("R5", "stream ready", 64'(mReady[0]), 64'h1);
      chk("R5", "stream address", 64'(sAddr), 64'(16'h4210 + k));
      nextCyc();
      setReq(0, 1'b1, 16'(16'h4210 + k + 1));
    end

    // R7: a lower-level waiter does not interrupt
    setReq(3, 1'b1, 16'h4300);
    setReq(0, 1'b1, 16'h4400);
    for (int k = 0; k < 4; k++) begin
      settle();
      chk("R7", "owner address", 64'(sAddr), 64'(16'h4400 + k));
      chk("R7", "waiter ready", 64'(mReady[3]), 64'h0);
      nextCyc();
      setReq(0, 1'b1, 16'(16'h4400 + k + 1));
    end
    setReq(0, 1'b0, '0);
    settle();
    chk("R9", "release idle cycle", 64'(sValid), 64'h0);
    nextCyc();
    settle();
    chk("R9", "released to waiter", 64'(sAddr), 64'h4300);
    chk("R9", "waiter ready", 64'(mReady[3]), 64'h1);
    nextCyc();
    setReq(3, 1'b0, '0);

    // R6: preemption at an accepted transfer
    setReq(3, 1'b1, 16'h4500);
    settle();
    chk("R6", "owner ready", 64'(mReady[3]), 64'h1);
    nextCyc();
    setReq(3, 1'b1, 16'h4501);
    setReq(0, 1'b1, 16'h4600);
    settle();
    chk("R6", "old owner accepted", 64'(mReady[3]), 64'h1);
    chk("R6", "old owner address", 64'(sAddr), 64'h4501);
    chk("R6", "newcomer not yet", 64'(mReady[0]), 64'h0);
    nextCyc();
    setReq(3, 1'b1, 16'h4502);
    settle();
    chk("R6", "single idle cycle", 64'(sValid), 64'h0);
    chk("R6", "no completion in gap", 64'(mReady), 64'h0);
    nextCyc();
    settle();
    chk("R6", "new owner address", 64'(sAddr), 64'h4600);
    chk("R6", "new owner ready", 64'(mReady[0]), 64'h1);
    chk("R6", "old owner held off", 64'(mReady[3]), 64'h0);
    nextCyc();
    setReq(0, 1'b0, '0);
    settle();
    chk("R9", "idle before return", 64'(sValid), 64'h0);
    nextCyc();
    settle();
    chk("R9", "port returns", 64'(sAddr), 64'h4502);
    chk("R9", "returning ready", 64'(mReady[3]), 64'h1);
    nextCyc();
    setReq(3, 1'b0, '0);

    // R9 / R3: release with two waiters picks the higher level
    xfer(0, 16'h4700, 1, 1'b0, "R9");
    setReq(0, 1'b1, 16'h4701);
    setReq(1, 1'b1, 16'h4801);
    setReq(2, 1'b1, 16'h4802);
    settle();
    chk("R7", "owner keeps port", 64'(sAddr), 64'h4701);
    chk("R7", "waiters held", 64'(mReady[2:1]), 64'h0);
    nextCyc();
    setReq(0, 1'b0, '0);
    settle();
    chk("R9", "idle after release", 64'(sValid), 64'h0);
    nextCyc();
    settle();
    chk("R3", "level 6 beats level 5", 64'(sAddr), 64'h4801);
    chk("R3", "winner ready", 64'(mReady[1]), 64'h1);
    chk("R3", "loser waits", 64'(mReady[2]), 64'h0);
    nextCyc();
    setReq(1, 1'b0, '0);
    settle();
    chk("R9", "idle before last waiter", 64'(sValid), 64'h0);
    nextCyc();
    settle();
    chk("R9", "last waiter served", 64'(sAddr), 64'h4802);
    chk("R9", "last waiter ready", 64'(mReady[2]), 64'h1);
    nextCyc();
    setReq(2, 1'b0, '0);

    // R8: wait states pin owner and address; a miss still completes
    xfer(3, 16'h4880, 1, 1'b0, "R8");
    setReq(3, 1'b1, 16'h4900);
    setReq(0, 1'b1, 16'h4A00);
    sReady = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (k == 1) setReq(2, 1'b1, 16'h7000);
      settle();
      chk("R8", "held address", 64'(sAddr), 64'h4900);
      chk("R8", "held sValid", 64'(sValid), 64'h1);
      chk("R8", "no owner completion", 64'(mReady[3]), 64'h0);
      chk("R8", "no preemption", 64'(mReady[0]), 64'h0);
      if (k == 1) begin
        chk("R2", "miss while busy ready", 64'(mReady[2]), 64'h1);
        chk("R2", "miss while busy error", 64'(mErr[2]), 64'h1);
      end
      nextCyc();
      if (k == 1) setReq(2, 1'b0, '0);
    end
    sReady = 1'b1;
    settle();
    chk("R8", "waited transfer completes", 64'(mReady[3]), 64'h1);
    chk("R8", "waited address", 64'(sAddr), 64'h4900);
    nextCyc();
    setReq(3, 1'b0, '0);
    settle();
    chk("R6", "gap after waited handoff", 64'(sValid), 64'h0);
    nextCyc();
    settle();
    chk("R6", "preempter served", 64'(sAddr), 64'h4A00);
    chk("R6", "preempter ready", 64'(mReady[0]), 64'h1);
    nextCyc();
    setReq(0, 1'b0, '0);

    // R10: slave error reaches only the owner
    sErr = 1'b1;
    xfer(0, 16'h4B00, 0, 1'b1, "R10");
    sErr = 1'b0;
    xfer(1, 16'h4B10, 1, 1'b0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule